// File: doc/BRIEF.md
# Transceiver Reset and Strap Sequencer

This block sequences reset for the digital core of a fast Ethernet transceiver. When power comes up it pulls a shared, open-drain reset line low and keeps it low until a supply-settle timer runs out. It then lets go of the line and waits until the line actually reads high. This lets any other device on the board keep the transceiver in reset for longer by holding the line low.

After start-up the same line acts as a hardware reset input. A low level that lasts long enough resets every section, including the analog one. While the line is low, the block latches two strap pins. One selects whether 100M capability is advertised and the other selects full duplex. A self-clearing software reset bit in control register 0 gives a partial reset: the management registers, the PCS state machines and the scramblers are reset, and the analog section is not.

Top module: `phy_rst_seq`

## Requirements
- R1: After `porN` is released, `rstDrvLow` stays 1 for exactly PWR_STABLE_CYC (default 10) clock cycles and then drops to 0. It does not assert again until the next `porN`.
- R2: Start-up and hardware-reset exit wait for the line to read high through a two-flop synchronizer. The reset enables drop 4 clock edges after `rstLineIn` goes high, however long something external holds the line low.
- R3: Once running, a low on `rstLineIn` that the synchronizer sees for HW_MIN_CYC (default 3) consecutive cycles asserts all four reset enables (`rstMgmt`, `rstPcs`, `rstScr`, `rstAnalog`). A shorter low asserts none of them.
- R4: `dataOutEn` is 0 whenever the block is held in reset, and it is 1 only while the block is running and the synchronized line is high.
- R5: When the block leaves reset, it latches `adv100` = NOT `spdStrap` and `advFull` = `dplxStrap`. Strap pin changes at any other time, including during a software reset, leave both outputs unchanged.
- R6: A control write (`ctrlWr`=1) with `ctrlWrBit15`=1 sets `swRstBit` to 1 after the write edge. The bit reads 1 for exactly one cycle and then clears itself.
- R7: In the cycle after `swRstBit` reads 1, `rstMgmt`, `rstPcs` and `rstScr` are 1 for exactly one cycle, and `rstAnalog` stays 0.
- R8: `lowPower` is 1 while the block is held in reset (power-up, a stretched line, or a hardware reset) and 0 while it is running.
- R9: A control write with `ctrlWrBit15`=0, or any control write while the block is held in reset, leaves `swRstBit` at 0 and causes no reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| rstLineIn | input | 1 | Level read back from the shared reset line |
| rstDrvLow | output | 1 | Open-drain pull-down enable for the reset line |
| spdStrap | input | 1 | Speed strap pin (low advertises 100M) |
| dplxStrap | input | 1 | Duplex strap pin (high advertises full duplex) |
| adv100 | output | 1 | Latched 100M advertisement |
| advFull | output | 1 | Latched full-duplex advertisement |
| ctrlWr | input | 1 | Write strobe for control register 0 |
| ctrlWrBit15 | input | 1 | Write data for bit 15 of control register 0 |
| swRstBit | output | 1 | Read value of the self-clearing reset bit |
| rstMgmt | output | 1 | Reset enable, management registers |
| rstPcs | output | 1 | Reset enable, PCS state machines |
| rstScr | output | 1 | Reset enable, scramblers |
| rstAnalog | output | 1 | Reset enable, analog section |
| dataOutEn | output | 1 | Enable for line-side and MII data outputs |
| lowPower | output | 1 | Static low-power request |

## Verification
The hardest case to reach from the ports is the exact boundary of the hardware-reset filter. Whether the reset is recognized depends on how many synchronized samples are low, not on how long the pin is low. The bench models the open-drain line as the wired AND of the block's own pull-down and an external hold. It sweeps hold lengths from one cycle to several cycles past the threshold, each with every strap combination. It also changes the straps after the latch point, so that a capture taken at the wrong edge shows up as a wrong advertisement.

// File: rtl/phy_rst_pkg.sv
package phy_rst_pkg;

  typedef enum logic [1:0] {
    ST_PWRUP = 2'd0,
    ST_WAIT  = 2'd1,
    ST_RUN   = 2'd2,
    ST_HWRST = 2'd3
  } seqState_t;

  typedef struct packed {
    logic drvLow;
    logic holdAll;
    logic latchStraps;
  } seqStrobe_t;

endpackage

// File: rtl/phy_rst_ctrl.sv
module phy_rst_ctrl
  import phy_rst_pkg::*;
#(
  parameter int PWR_STABLE_CYC = 10,
  parameter int HW_MIN_CYC     = 3
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       lineSync,
  output seqStrobe_t strobe
);

  localparam int MAX_CYC = (PWR_STABLE_CYC > HW_MIN_CYC) ? PWR_STABLE_CYC : HW_MIN_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PWR_LAST = CNT_W'(PWR_STABLE_CYC - 1);
  localparam logic [CNT_W-1:0] HW_LAST  = CNT_W'(HW_MIN_CYC - 1);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      state <= ST_PWRUP;
      cnt   <= '0;
    end else begin
      case (state)
        ST_PWRUP: begin
          if (cnt == PWR_LAST) begin
            state <= ST_WAIT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (lineSync) state <= ST_RUN;
          cnt <= '0;
        end
        ST_RUN: begin
          if (lineSync) begin
            cnt <= '0;
          end else if (cnt == HW_LAST) begin
            state <= ST_HWRST;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (lineSync) state <= ST_RUN;
          cnt <= '0;
        end
      endcase
    end
  end

  always_comb begin
    strobe.drvLow      = (state == ST_PWRUP);
    strobe.holdAll     = (state != ST_RUN);
    strobe.latchStraps = ((state == ST_WAIT) || (state == ST_HWRST)) && lineSync;
  end

endmodule

// File: rtl/phy_rst_dp.sv
module phy_rst_dp
  import phy_rst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  seqStrobe_t strobe,
  input  logic       rstLineIn,
  input  logic       spdStrap,
  input  logic       dplxStrap,
  input  logic       ctrlWr,
  input  logic       ctrlWrBit15,
  output logic       lineSync,
  output logic       adv100,
  output logic       advFull,
  output logic       swRstBit,
  output logic       rstMgmt,
  output logic       rstPcs,
  output logic       rstScr,
  output logic       rstAnalog,
  output logic       dataOutEn,
  output logic       lowPower
);

  logic [SYNC_STAGES-1:0] syncChain;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) syncChain[g] <= 1'b0;
        else if (g == 0) syncChain[g] <= rstLineIn;
        else syncChain[g] <= syncChain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign lineSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      adv100  <= 1'b0;
      advFull <= 1'b0;
    end else if (strobe.latchStraps) begin
      adv100  <= ~spdStrap;
      advFull <= dplxStrap;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) swRstBit <= 1'b0;
    else if (strobe.holdAll || swRstBit) swRstBit <= 1'b0;
    else if (ctrlWr && ctrlWrBit15) swRstBit <= 1'b1;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      rstMgmt   <= 1'b1;
      rstPcs    <= 1'b1;
      rstScr    <= 1'b1;
      rstAnalog <= 1'b1;
      dataOutEn <= 1'b0;
      lowPower  <= 1'b1;
    end else begin
      rstMgmt   <= strobe.holdAll | swRstBit;
      rstPcs    <= strobe.holdAll | swRstBit;
      rstScr    <= strobe.holdAll | swRstBit;
      rstAnalog <= strobe.holdAll;
      dataOutEn <= ~strobe.holdAll & lineSync;
      lowPower  <= strobe.holdAll;
    end
  end

endmodule

// File: rtl/phy_rst_seq.sv
module phy_rst_seq
  import phy_rst_pkg::*;
#(
  parameter int PWR_STABLE_CYC = 10,
  parameter int HW_MIN_CYC     = 3,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic porN,
  input  logic rstLineIn,
  output logic rstDrvLow,
  input  logic spdStrap,
  input  logic dplxStrap,
  output logic adv100,
  output logic advFull,
  input  logic ctrlWr,
  input  logic ctrlWrBit15,
  output logic swRstBit,
  output logic rstMgmt,
  output logic rstPcs,
  output logic rstScr,
  output logic rstAnalog,
  output logic dataOutEn,
  output logic lowPower
);

  seqStrobe_t strobe;
  logic       lineSync;

  phy_rst_ctrl #(
    .PWR_STABLE_CYC(PWR_STABLE_CYC),
    .HW_MIN_CYC    (HW_MIN_CYC)
  ) u_ctrl (
    .clk     (clk),
    .porN    (porN),
    .lineSync(lineSync),
    .strobe  (strobe)
  );

  phy_rst_dp #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .porN       (porN),
    .strobe     (strobe),
    .rstLineIn  (rstLineIn),
    .spdStrap   (spdStrap),
    .dplxStrap  (dplxStrap),
    .ctrlWr     (ctrlWr),
    .ctrlWrBit15(ctrlWrBit15),
    .lineSync   (lineSync),
    .adv100     (adv100),
    .advFull    (advFull),
    .swRstBit   (swRstBit),
    .rstMgmt    (rstMgmt),
    .rstPcs     (rstPcs),
    .rstScr     (rstScr),
    .rstAnalog  (rstAnalog),
    .dataOutEn  (dataOutEn),
    .lowPower   (lowPower)
  );

  assign rstDrvLow = strobe.drvLow;

endmodule

// File: rtl/phy_rst_seq_chk.sv
module phy_rst_seq_chk (
  input logic clk,
  input logic porN,
  input logic rstDrvLow,
  input logic adv100,
  input logic advFull,
  input logic swRstBit,
  input logic rstMgmt,
  input logic rstPcs,
  input logic rstScr,
  input logic rstAnalog,
  input logic dataOutEn,
  input logic lowPower
);

  p_drv_once_r1: assert property (@(posedge clk) disable iff (!porN)
    !rstDrvLow |=> !rstDrvLow);

  p_drv_full_reset_r1: assert property (@(posedge clk) disable iff (!porN)
    rstDrvLow |-> (rstAnalog && rstMgmt && lowPower));

  p_data_off_r4: assert property (@(posedge clk) disable iff (!porN)
    rstAnalog |-> !dataOutEn);

  p_strap_hold_r5: assert property (@(posedge clk) disable iff (!porN)
    (!lowPower && $past(!lowPower)) |-> ($stable(adv100) && $stable(advFull)));

  p_bit_selfclear_r6: assert property (@(posedge clk) disable iff (!porN)
    swRstBit |=> !swRstBit);

  p_sw_pulse_r7: assert property (@(posedge clk) disable iff (!porN)
    (rstMgmt && !rstAnalog) |=> (!rstMgmt || rstAnalog));

  p_sw_group_r7: assert property (@(posedge clk) disable iff (!porN)
    (rstMgmt == rstPcs) && (rstPcs == rstScr));

endmodule

bind phy_rst_seq phy_rst_seq_chk u_chk (
  .clk      (clk),
  .porN     (porN),
  .rstDrvLow(rstDrvLow),
  .adv100   (adv100),
  .advFull  (advFull),
  .swRstBit (swRstBit),
  .rstMgmt  (rstMgmt),
  .rstPcs   (rstPcs),
  .rstScr   (rstScr),
  .rstAnalog(rstAnalog),
  .dataOutEn(dataOutEn),
  .lowPower (lowPower)
);

// File: tb/phy_rst_seq_tb.sv
`timescale 1ns/1ps
module phy_rst_seq_tb;

  localparam int PWR = 10;
  localparam int HWM = 3;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic extHold = 1'b0;
  logic spdStrap = 1'b1;
  logic dplxStrap = 1'b0;
  logic ctrlWr = 1'b0;
  logic ctrlWrBit15 = 1'b0;
  logic rstDrvLow, adv100, advFull, swRstBit;
  logic rstMgmt, rstPcs, rstScr, rstAnalog, dataOutEn, lowPower;
  logic rstLineIn;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  assign rstLineIn = !(rstDrvLow || extHold);

  phy_rst_seq #(.PWR_STABLE_CYC(PWR), .HW_MIN_CYC(HWM)) u_dut (
    .clk(clk), .porN(porN), .rstLineIn(rstLineIn), .rstDrvLow(rstDrvLow),
    .spdStrap(spdStrap), .dplxStrap(dplxStrap), .adv100(adv100), .advFull(advFull),
    .ctrlWr(ctrlWr), .ctrlWrBit15(ctrlWrBit15), .swRstBit(swRstBit),
    .rstMgmt(rstMgmt), .rstPcs(rstPcs), .rstScr(rstScr), .rstAnalog(rstAnalog),
    .dataOutEn(dataOutEn), .lowPower(lowPower)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkRun(input string tag);
    chk({tag, " rstMgmt"}, rstMgmt, 0);
    chk({tag, " rstPcs"}, rstPcs, 0);
    chk({tag, " rstScr"}, rstScr, 0);
    chk({tag, " rstAnalog"}, rstAnalog, 0);
    chk({tag, " dataOutEn"}, dataOutEn, 1);
    chk({tag, " lowPower"}, lowPower, 0);
  endtask

  // Hold the line low for len cycles, then release and settle.
  task automatic hwPulse(input int len, input logic spd, input logic dplx);
    int seenRst = 0;
    int seenDataOn = 0;
    int seenLp = 0;
    int expAdv100 = adv100;
    int expFull = advFull;
    bit expectReset = (len >= HWM);
    spdStrap = spd;
    dplxStrap = dplx;
    extHold = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (rstAnalog || rstMgmt) seenRst = 1;
    end
    extHold = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (rstAnalog || rstMgmt) seenRst = 1;
      if (lowPower) seenLp = 1;
      if (rstAnalog && dataOutEn) seenDataOn = 1;
    end
    if (expectReset) begin
      expAdv100 = !spd;
      expFull = dplx;
    end
    chk($sformatf("R3 reset seen len=%0d", len), seenRst, expectReset);
    chk($sformatf("R8 lowPower seen len=%0d", len), seenLp, expectReset);
    chk($sformatf("R4 data off in reset len=%0d", len), seenDataOn, 0);
    chk($sformatf("R5 adv100 len=%0d", len), adv100, expAdv100);
    chk($sformatf("R5 advFull len=%0d", len), advFull, expFull);
    chkRun("R3 settled");
    spdStrap = !spd;
    dplxStrap = !dplx;
    repeat (3) @(negedge clk);
    chk("R5 adv100 ignores pin change", adv100, expAdv100);
    chk("R5 advFull ignores pin change", advFull, expFull);
  endtask

  task automatic swWrite(input logic b);
    int a100 = adv100;
    int aFull = advFull;
    ctrlWr = 1'b1;
    ctrlWrBit15 = b;
    @(negedge clk);
    ctrlWr = 1'b0;
    ctrlWrBit15 = 1'b0;
    chk(b ? "R6 bit set" : "R9 bit stays clear", swRstBit, b);
    chk("R7 no pulse yet", rstMgmt, 0);
    @(negedge clk);
    chk(b ? "R7 rstMgmt pulse" : "R9 no rstMgmt", rstMgmt, b);
    chk(b ? "R7 rstPcs pulse" : "R9 no rstPcs", rstPcs, b);
    chk(b ? "R7 rstScr pulse" : "R9 no rstScr", rstScr, b);
    chk("R7 analog untouched", rstAnalog, 0);
    chk("R6 bit self-clears", swRstBit, 0);
    @(negedge clk);
    chk("R7 pulse one cycle", rstMgmt, 0);
    chk("R7 rstScr one cycle", rstScr, 0);
    chk("R5 straps kept over sw reset", adv100, a100);
    chk("R5 duplex kept over sw reset", advFull, aFull);
  endtask

  initial begin
    #4_000_000;
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    spdStrap = 1'b0;
    dplxStrap = 1'b1;
    extHold = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 drive low in por", rstDrvLow, 1);
    chk("R1 analog in por", rstAnalog, 1);
    chk("R4 data off in por", dataOutEn, 0);
    chk("R8 lowPower in por", lowPower, 1);
    chk("R6 bit clear in por", swRstBit, 0);
    porN = 1'b1;
    for (int k = 1; k <= PWR + 1; k++) begin
      @(negedge clk);
      chk($sformatf("R1 drvLow after edge %0d", k), rstDrvLow, (k < PWR) ? 1 : 0);
    end
    // R2: external stretch keeps reset asserted
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R2 stretched rstMgmt", rstMgmt, 1);
      chk("R8 stretched lowPower", lowPower, 1);
      chk("R4 stretched data off", dataOutEn, 0);
    end
    extHold = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk($sformatf("R2 release edge %0d", k), rstAnalog, (k < 4) ? 1 : 0);
    end
    chkRun("R2 running");
    chk("R5 adv100 from low strap", adv100, 1);
    chk("R5 advFull from high strap", advFull, 1);
    spdStrap = 1'b1;
    dplxStrap = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5 adv100 pin ignored", adv100, 1);
    chk("R5 advFull pin ignored", advFull, 1);

    // R3 sweep: hold lengths around the threshold for all strap combos
    for (int len = 1; len <= HWM + 4; len++) begin
      for (int s = 0; s < 4; s++) begin
        hwPulse(len, s[0], s[1]);
      end
    end

    swWrite(1'b1);
    swWrite(1'b0);
    repeat (2) @(negedge clk);
    swWrite(1'b1);

    // R9: write while held in reset
    extHold = 1'b1;
    repeat (8) @(negedge clk);
    ctrlWr = 1'b1;
    ctrlWrBit15 = 1'b1;
    @(negedge clk);
    ctrlWr = 1'b0;
    ctrlWrBit15 = 1'b0;
    chk("R9 write in reset ignored", swRstBit, 0);
    @(negedge clk);
    chk("R9 bit still clear", swRstBit, 0);
    chk("R3 analog held", rstAnalog, 1);
    extHold = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 no bit after release", swRstBit, 0);
    chkRun("R9 running");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule